// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Logic Unit

This block is a purely combinational ALU of parameterizable width. It has an arithmetic half and a logic half. The arithmetic half is a ripple-carry adder. Its first operand is always A. Its second operand, Y, is steered by a two-bit function select to zero, B, the bitwise inverse of B, or all ones. A separate carry input is added in as well. These four operand choices and the two carry values give eight arithmetic results without any dedicated subtractor or incrementer.

The logic half reads the same two-bit function select and produces one of four bitwise functions. A single mode line picks which half drives the result. The datapath is one bit-slice repeated once per bit, with the carry passed from bit 0 toward the most significant bit.

The block has no clock and no handshake, so the outputs follow the inputs within the same cycle. A surrounding datapath registers the result wherever it needs to.

Top module: `sel_alu`

## Requirements
- R1: With `logic_mode`=0 and `fn_sel`=00 (Y is zero), `res` equals `opa + cin` modulo 2^WIDTH. `cout` is the carry out of that sum: it is 1 only when `opa` is all ones and `cin`=1.
- R2: With `logic_mode`=0 and `fn_sel`=01 (Y is B), `res` equals `opa + opb + cin` modulo 2^WIDTH. `cout` is bit WIDTH of the full sum.
- R3: With `logic_mode`=0 and `fn_sel`=10 (Y is the inverse of B), `res` equals `opa + ~opb + cin`. With `cin`=1 this is `opa - opb`, and `cout`=1 exactly when `opa >= opb` unsigned. In particular, equal operands give `res`=0 with `cout`=1.
- R4: With `logic_mode`=0 and `fn_sel`=11 (Y is all ones), `cin`=0 gives `opa - 1` with `cout`=1 unless `opa` is 0. `cin`=1 gives `res`=`opa` with `cout`=1.
- R5: With `logic_mode`=1, `fn_sel` selects a bitwise function: 00 gives AND, 01 gives OR, 10 gives XOR, and 11 gives NOT `opa`. For NOT, `opb` has no effect on `res`.
- R6: With `logic_mode`=1, `cin` has no effect on `res`, and both `cout` and `ovf` are 0.
- R7: With `logic_mode`=0, `ovf` is 1 exactly when the carry into the top bit differs from the carry out of it. This is the same as saying that A and Y have the same sign bit and the result's sign bit differs from it.
- R8: The width is the parameter WIDTH, with a default of 8. The carry ripples from bit 0 through every bit, so an all-ones value plus a carry-in of 1 gives a zero result with `cout`=1 at any width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand A, always fed straight to the adder |
| opb | input | WIDTH | Second operand B, steered into Y or used by the logic functions |
| fn_sel | input | 2 | Function select shared by both halves (Y source or logic function) |
| logic_mode | input | 1 | 0 selects the arithmetic result, 1 selects the logic result |
| cin | input | 1 | Carry into bit 0 of the adder |
| res | output | WIDTH | Selected result |
| cout | output | 1 | Carry out of the top bit; 0 in logic mode |
| ovf | output | 1 | Signed overflow of the arithmetic result; 0 in logic mode |

## Verification
The bench builds two copies of the block.

The first copy uses the default width of 8. It is driven with directed corner values: the sign boundary at 0x7F/0x80, all ones, zero, equal operands for subtraction, and the full carry chain from all ones plus one. These vectors cover each arithmetic and logic function.

The second copy has a width of 3. It is small enough to be swept over every combination of both operands, all eight select and mode codes, and both carry-in values. The sweep reaches every overflow and carry case at the smallest width that still has a distinct sign bit, interior bit and bottom bit.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;

  // Operand steering codes for the adder's second input (arithmetic mode).
  typedef enum logic [1:0] {
    YSRC_ZERO = 2'b00,
    YSRC_B    = 2'b01,
    YSRC_NOTB = 2'b10,
    YSRC_ONES = 2'b11
  } ysrc_e;

  // Bitwise function codes (logic mode), sharing the same select pins.
  typedef enum logic [1:0] {
    LFN_AND  = 2'b00,
    LFN_OR   = 2'b01,
    LFN_XOR  = 2'b10,
    LFN_NOTA = 2'b11
  } lfn_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import sel_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       c_i,
  input  logic [1:0] fn_i,
  input  logic       lmode_i,
  output logic       r_o,
  output logic       c_o
);

  logic y_bit;
  logic sum_bit;
  logic log_bit;
  logic half;

  // Y steering reduced from a 4:1 mux: bit 0 passes B, bit 1 passes ~B,
  // both together give 1, neither gives 0.
  assign y_bit = (b_i & fn_i[0]) | (~b_i & fn_i[1]);

  // Full adder
  assign half    = a_i ^ y_bit;
  assign sum_bit = half ^ c_i;
  assign c_o     = (a_i & y_bit) | (c_i & half);

  always_comb begin
    unique case (lfn_e'(fn_i))
      LFN_AND:  log_bit = a_i & b_i;
      LFN_OR:   log_bit = a_i | b_i;
      LFN_XOR:  log_bit = a_i ^ b_i;
      default:  log_bit = ~a_i;
    endcase
  end

  assign r_o = lmode_i ? log_bit : sum_bit;

endmodule

// File: rtl/alu_status.sv
module alu_status (
  input  logic lmode_i,
  input  logic c_top_in_i,
  input  logic c_top_out_i,
  output logic cout_o,
  output logic ovf_o
);

  // Flags are meaningful only for arithmetic; forced low in logic mode.
  assign cout_o = ~lmode_i & c_top_out_i;
  assign ovf_o  = ~lmode_i & (c_top_in_i ^ c_top_out_i);

endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       fn_sel,
  input  logic             logic_mode,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry;

  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      alu_bit_slice u_bit (
        .a_i     (opa[i]),
        .b_i     (opb[i]),
        .c_i     (carry[i]),
        .fn_i    (fn_sel),
        .lmode_i (logic_mode),
        .r_o     (res[i]),
        .c_o     (carry[i+1])
      );
    end
  endgenerate

  alu_status u_status (
    .lmode_i     (logic_mode),
    .c_top_in_i  (carry[MSB]),
    .c_top_out_i (carry[WIDTH]),
    .cout_o      (cout),
    .ovf_o       (ovf)
  );

  always_comb begin
    if (logic_mode) begin
      // R6
      logic_flags_chk: assert (cout == 1'b0 && ovf == 1'b0);
    end
    if (logic_mode && fn_sel == LFN_NOTA) begin
      // R5
      not_a_chk: assert (res == ~opa);
    end
    if (!logic_mode && fn_sel == YSRC_ZERO && !cin) begin
      // R1
      pass_a_chk: assert (res == opa && !cout && !ovf);
    end
    if (!logic_mode && fn_sel == YSRC_ONES && cin) begin
      // R4
      keep_a_chk: assert (res == opa && cout && !ovf);
    end
    if (!logic_mode && fn_sel == YSRC_NOTB && cin && opa == opb) begin
      // R3
      sub_equal_chk: assert (res == '0 && cout);
    end
  end

endmodule

// File: tb/sim_sel_alu.sv
module sim_sel_alu;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Wide instance
  logic [7:0] a0 = '0, b0 = '0;
  logic [1:0] fn0 = '0;
  logic       lm0 = 1'b0, ci0 = 1'b0;
  logic [7:0] r0;
  logic       co0, ov0;

  // Narrow instance
  logic [2:0] a1 = '0, b1 = '0;
  logic [1:0] fn1 = '0;
  logic       lm1 = 1'b0, ci1 = 1'b0;
  logic [2:0] r1;
  logic       co1, ov1;

  sel_alu #(.WIDTH(8)) u0 (
    .opa(a0), .opb(b0), .fn_sel(fn0), .logic_mode(lm0), .cin(ci0),
    .res(r0), .cout(co0), .ovf(ov0)
  );

  sel_alu #(.WIDTH(3)) u1 (
    .opa(a1), .opb(b1), .fn_sel(fn1), .logic_mode(lm1), .cin(ci1),
    .res(r1), .cout(co1), .ovf(ov1)
  );

  // Reference model from the requirements, in integer arithmetic.
  task automatic model(input int w, input int a, input int b, input logic lm,
                       input int fn, input logic ci,
                       output int er, output logic eco, output logic eov);
    int mask, y, s, sa, sy, sr;
    mask = (1 << w) - 1;
    if (!lm) begin
      case (fn)
        0: y = 0;
        1: y = b;
        2: y = (~b) & mask;
        default: y = mask;
      endcase
      s   = a + y + int'(ci);
      er  = s & mask;
      eco = ((s >> w) & 1) != 0;
      sa  = (a >> (w - 1)) & 1;
      sy  = (y >> (w - 1)) & 1;
      sr  = (er >> (w - 1)) & 1;
      eov = (sa == sy) && (sr != sa);
    end else begin
      case (fn)
        0: er = a & b;
        1: er = a | b;
        2: er = a ^ b;
        default: er = (~a) & mask;
      endcase
      eco = 1'b0;
      eov = 1'b0;
    end
  endtask

  task automatic cmp(input string tag, input int a, input int b, input logic lm,
                     input int fn, input logic ci, input int gr, input logic gco,
                     input logic gov, input int er, input logic eco, input logic eov);
    checks++;
    if (gr != er || gco !== eco || gov !== eov) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h mode=%0b fn=%0d cin=%0b: got res=%0h co=%0b ov=%0b exp res=%0h co=%0b ov=%0b",
               tag, a, b, lm, fn, ci, gr, gco, gov, er, eco, eov);
    end
  endtask

  task automatic apply8(input string tag, input int a, input int b, input logic lm,
                        input int fn, input logic ci);
    int er; logic eco, eov;
    @(posedge clk); #3;
    a0 = a[7:0]; b0 = b[7:0]; lm0 = lm; fn0 = fn[1:0]; ci0 = ci;
    #5;
    model(8, a & 8'hFF, b & 8'hFF, lm, fn, ci, er, eco, eov);
    cmp(tag, a, b, lm, fn, ci, int'(r0), co0, ov0, er, eco, eov);
  endtask

  // Hand-computed expectation, independent of the model.
  task automatic lit8(input string tag, input int a, input int b, input logic lm,
                      input int fn, input logic ci, input int er, input logic eco,
                      input logic eov);
    @(posedge clk); #3;
    a0 = a[7:0]; b0 = b[7:0]; lm0 = lm; fn0 = fn[1:0]; ci0 = ci;
    #5;
    cmp(tag, a, b, lm, fn, ci, int'(r0), co0, ov0, er, eco, eov);
  endtask

  task automatic t_idle;
    lit8("R1 idle", 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic t_pass_inc;
    foreach (a_vals[k]) begin
      apply8("R1", a_vals[k], 8'h3C, 1'b0, 0, 1'b0);
      apply8("R1", a_vals[k], 8'hC3, 1'b0, 0, 1'b1);
    end
    lit8("R1 inc", 8'h41, 8'h00, 1'b0, 0, 1'b1, 8'h42, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    for (int k = 0; k < 16; k++) begin
      apply8("R2", k * 17, 255 - k * 13, 1'b0, 1, k[0]);
    end
    lit8("R2 add", 8'hF0, 8'h20, 1'b0, 1, 1'b1, 8'h11, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    lit8("R3 lt", 5, 7, 1'b0, 2, 1'b1, 8'hFE, 1'b0, 1'b0);
    lit8("R3 eq", 8'h9A, 8'h9A, 1'b0, 2, 1'b1, 8'h00, 1'b1, 1'b0);
    lit8("R3 gt", 8'hC8, 8'h0A, 1'b0, 2, 1'b1, 8'hBE, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++) begin
      apply8("R3", k * 23, k * 19 + 5, 1'b0, 2, k[1]);
    end
  endtask

  task automatic t_dec;
    lit8("R4 dec0", 0, 8'h55, 1'b0, 3, 1'b0, 8'hFF, 1'b0, 1'b0);
    lit8("R4 dec", 8'h10, 8'h55, 1'b0, 3, 1'b0, 8'h0F, 1'b1, 1'b0);
    lit8("R4 keep", 8'h6D, 8'h12, 1'b0, 3, 1'b1, 8'h6D, 1'b1, 1'b0);
    lit8("R4 dec80", 8'h80, 8'h00, 1'b0, 3, 1'b0, 8'h7F, 1'b1, 1'b1);
  endtask

  task automatic t_logic;
    lit8("R5 and", 8'hCC, 8'hAA, 1'b1, 0, 1'b0, 8'h88, 1'b0, 1'b0);
    lit8("R5 or",  8'hCC, 8'hAA, 1'b1, 1, 1'b0, 8'hEE, 1'b0, 1'b0);
    lit8("R5 xor", 8'hCC, 8'hAA, 1'b1, 2, 1'b0, 8'h66, 1'b0, 1'b0);
    lit8("R5 not", 8'hCC, 8'hAA, 1'b1, 3, 1'b0, 8'h33, 1'b0, 1'b0);
    lit8("R5 not b", 8'hCC, 8'h00, 1'b1, 3, 1'b0, 8'h33, 1'b0, 1'b0);
  endtask

  task automatic t_logic_ignore;
    for (int f = 0; f < 4; f++) begin
      apply8("R6 cin0", 8'hFF, 8'hFF, 1'b1, f, 1'b0);
      apply8("R6 cin1", 8'hFF, 8'hFF, 1'b1, f, 1'b1);
      apply8("R6 cin1", 8'h80, 8'h80, 1'b1, f, 1'b1);
    end
  endtask

  task automatic t_ovf;
    lit8("R7 pos", 8'h7F, 8'h01, 1'b0, 1, 1'b0, 8'h80, 1'b0, 1'b1);
    lit8("R7 neg", 8'h80, 8'h80, 1'b0, 1, 1'b0, 8'h00, 1'b1, 1'b1);
    lit8("R7 sub", 8'h80, 8'h01, 1'b0, 2, 1'b1, 8'h7F, 1'b1, 1'b1);
    lit8("R7 subn", 8'h7F, 8'hFF, 1'b0, 2, 1'b1, 8'h80, 1'b0, 1'b1);
    lit8("R7 none", 8'h7F, 8'h00, 1'b0, 1, 1'b0, 8'h7F, 1'b0, 1'b0);
    lit8("R7 mix", 8'h7F, 8'h80, 1'b0, 1, 1'b1, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_ripple;
    lit8("R8 chain", 8'hFF, 8'h00, 1'b0, 0, 1'b1, 8'h00, 1'b1, 1'b0);
    lit8("R8 chainb", 8'hFE, 8'h01, 1'b0, 1, 1'b1, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_narrow_sweep;
    int er; logic eco, eov;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int m = 0; m < 16; m++) begin
          @(posedge clk); #3;
          a1 = a[2:0]; b1 = b[2:0]; lm1 = m[3]; fn1 = m[2:1]; ci1 = m[0];
          #5;
          model(3, a, b, m[3], int'(m[2:1]), m[0], er, eco, eov);
          cmp("R8 w3", a, b, m[3], int'(m[2:1]), m[0], int'(r1), co1, ov1, er, eco, eov);
        end
  endtask

  int a_vals [4] = '{8'h00, 8'h7F, 8'hFF, 8'h55};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles exp under 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_pass_inc();
    t_add();
    t_sub();
    t_dec();
    t_logic();
    t_logic_ignore();
    t_ovf();
    t_ripple();
    t_narrow_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule